// File: doc/BRIEF.md
# Error-Tolerant Flash Thermometer Encoder

This block sits behind the comparator bank of a flash analog-to-digital converter. For a converter of `RES_BITS` bits it takes a word of 2^RES_BITS-1 comparator decisions. In a clean word every comparator whose threshold lies below the input reads 1, so the word is a run of ones starting at bit 0. The block reduces this word to a `RES_BITS`-bit binary level.

Real comparator banks produce sparkles and metastable bits, so a plain count of ones or a plain OR of code rows is not safe. A compile-time parameter selects one of two hardened encoders.

- **Row encoder:** a three-input boundary detector feeds a row encoder that selects the highest active row.
- **Gray encoder:** the word is mapped directly to a Gray code, so each comparator bit drives exactly one Gray bit. The Gray code is then decoded to binary.

Both encoders register their intermediate word, then register the binary result. The latency is therefore the same whichever encoder is built.

Top module: `flash_therm_enc`

## Requirements
- R1: A valid clean word whose lowest k bits are 1 and all other bits 0 produces `code_o` = k, for every k and for both encoders.
- R2: An all-zero valid word produces `code_o` = 0, and an all-ones valid word produces `code_o` = 2^RES_BITS-1.
- R3: `code_vld_o` is high at exactly the second rising edge after a rising edge that samples `therm_vld_i` high. The code shown with it belongs to that sample, and results come out in input order.
- R4: A rising edge that samples `therm_vld_i` low leads, two edges later, to `code_vld_o` low with `code_o` unchanged from the previous cycle.
- R5: Reset is synchronous and active low. After any rising edge with `rst_n` low, `code_o` is 0 and `code_vld_o` is 0, whatever `therm_i` and `therm_vld_i` carry.
- R6: Row encoder, boundary rule. Let T_k = `therm_i[k-1]` for k = 1..2^RES_BITS-1, with T_-1 = T_0 = 1 and T_(max+1) = 0. Row i is active only when T_(i-1) = 1, T_i = 1 and T_(i+1) = 0. As a result, a lone 1 sitting above a clean run with zeros on both sides lights no row and is ignored. Example for RES_BITS = 4: `therm_i` = 15'h011F gives 5.
- R7: Row encoder, multiple rows. When several rows are active, the code is the index of the highest active row and never the OR of several rows. Example for RES_BITS = 4: 15'h00F7 gives 8, and 15'h3EFF gives 14.
- R8: Gray encoder. Gray bit j is the OR, over m = 2^j + n*2^(j+2) with m <= 2^RES_BITS-1, of T_m AND NOT T_(m+2^(j+1)); any T above the top comparator counts as 0. Binary bit RES_BITS-1 equals Gray bit RES_BITS-1, and every lower binary bit k is binary bit k+1 XOR Gray bit k. Example for RES_BITS = 4: 15'h00F7 gives 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_i | input | 2^RES_BITS-1 | Comparator decisions; bit 0 is the lowest threshold |
| therm_vld_i | input | 1 | Marks `therm_i` as a sample to convert |
| code_o | output | RES_BITS | Binary conversion result |
| code_vld_o | output | 1 | Marks `code_o` as a fresh result |

## Verification
On every cycle, the bound checker checks four things:
- the two-edge valid latency;
- that the code holds across idle cycles;
- the reset values;
- that any clean or all-ones word seen two edges earlier comes out as its count of ones.

The checker cannot check corrupted words, because it keeps no model of either encoder. Only the bench scenarios show the sparkle behaviour of the row encoder: a lone 1 ignored, and the highest of two rows chosen. The same holds for the Gray encoder's results on bubbled words. The bench checks these against models built from R6 to R8, with both encoders instantiated side by side.

// File: rtl/fte_pkg.sv
// Shared definitions for the flash thermometer encoder.
// Assumes: nothing beyond IEEE 1800-2017.
package fte_pkg;

    // Which hardened encoder a build uses
    typedef enum logic {
        ENC_ROWS = 1'b0,   // three-input boundary rows + highest-row encoder
        ENC_GRAY = 1'b1    // direct thermometer-to-Gray map + Gray decoder
    } enc_style_e;

    // Number of comparators for a given resolution
    function automatic int cmp_count(input int bits);
        return (1 << bits) - 1;
    endfunction

endpackage

// File: rtl/fte_row_detect.sv
// Three-input boundary detector.
// Row i is lit when the two thresholds at and below level i read 1 and the
// one above reads 0. Two virtual ones sit below bit 0 and a virtual zero sits
// above the top bit, so rows 0 and N_CMP follow the same rule.
// Assumes: therm_i bit 0 is the lowest threshold.
module fte_row_detect #(
    parameter int N_CMP = 15
) (
    input  logic [N_CMP-1:0] therm_i,
    output logic [N_CMP:0]   rows_o
);

    localparam int EXT_W = N_CMP + 3;

    logic [EXT_W-1:0] ext;

    // Pad the word with the virtual levels at both ends
    assign ext = {1'b0, therm_i, 2'b11};

    genvar gi;
    generate
        for (gi = 0; gi <= N_CMP; gi++) begin : g_row
            // One boundary term: below-one, at-one, above-zero
            assign rows_o[gi] = ext[gi] & ext[gi+1] & ~ext[gi+2];
        end
    endgenerate

endmodule

// File: rtl/fte_row_rom.sv
// Row encoder with priority.
// Returns the index of the highest lit row, so that two lit rows never merge
// into a wrong OR-ed code.
// Assumes: at least one row is lit. The boundary rule guarantees this; an
// all-zero input returns 0.
module fte_row_rom #(
    parameter int N_CMP    = 15,
    parameter int RES_BITS = 4
) (
    input  logic [N_CMP:0]    rows_i,
    output logic [RES_BITS-1:0] code_o
);

    // Scan upward; a later (higher) hit overrides an earlier one
    always_comb begin
        code_o = '0;
        for (int i = 0; i <= N_CMP; i++) begin
            if (rows_i[i]) begin
                code_o = RES_BITS'(i);
            end
        end
    end

endmodule

// File: rtl/fte_gray_map.sv
// Direct thermometer-to-Gray map.
// Gray bit j ORs terms T[m] & ~T[m + 2^(j+1)], with m stepping by 2^(j+2)
// from 2^j. Every threshold appears in exactly one Gray bit.
// Assumes: T[k] = therm_i[k-1]; thresholds above the top comparator read 0.
module fte_gray_map #(
    parameter int RES_BITS = 4,
    parameter int N_CMP    = (1 << RES_BITS) - 1
) (
    input  logic [N_CMP-1:0]    therm_i,
    output logic [RES_BITS-1:0] gray_o
);

    localparam int PAD_W = 2 * N_CMP + 2;

    logic [PAD_W-1:0] pad;

    // Zero-extend so that upper partners beyond the top read 0
    assign pad = {{(PAD_W - N_CMP){1'b0}}, therm_i};

    // Build each Gray bit from its own disjoint set of thresholds
    always_comb begin
        for (int j = 0; j < RES_BITS; j++) begin
            logic acc;
            acc = 1'b0;
            for (int m = (1 << j); m <= N_CMP; m += (1 << (j + 2))) begin
                acc = acc | (pad[m-1] & ~pad[m + (1 << (j + 1)) - 1]);
            end
            gray_o[j] = acc;
        end
    end

endmodule

// File: rtl/fte_gray_decode.sv
// Gray-to-binary decoder, computed from the MSB down as a running XOR.
// Assumes: gray_i is already registered upstream.
module fte_gray_decode #(
    parameter int RES_BITS = 4
) (
    input  logic [RES_BITS-1:0] gray_i,
    output logic [RES_BITS-1:0] bin_o
);

    // Running parity from the top bit down
    always_comb begin
        logic par;
        par = 1'b0;
        for (int k = RES_BITS - 1; k >= 0; k--) begin
            par      = par ^ gray_i[k];
            bin_o[k] = par;
        end
    end

endmodule

// File: rtl/flash_therm_enc.sv
// Error-tolerant flash thermometer encoder (top).
// ENC_STYLE picks the encoder:
//   ENC_ROWS: boundary rows, registered, then the highest-row encoder;
//   ENC_GRAY: direct Gray map, registered, then the Gray decoder.
// Both encoders register twice, so a sample taken at edge n is presented
// after edge n+2. Registers load only on valid samples.
// Assumes: RES_BITS in 3..6; rst_n is synchronous and active low.
module flash_therm_enc
    import fte_pkg::*;
#(
    parameter int         RES_BITS  = 4,
    parameter enc_style_e ENC_STYLE = ENC_ROWS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [(2**RES_BITS)-2:0]    therm_i,
    input  logic                        therm_vld_i,
    output logic [RES_BITS-1:0]         code_o,
    output logic                        code_vld_o
);

    localparam int N_CMP = cmp_count(RES_BITS);

    logic                s1_vld;
    logic [RES_BITS-1:0] s1_code;

    generate
        if (ENC_STYLE == ENC_ROWS) begin : g_rows
            logic [N_CMP:0]      row_hit;
            logic [N_CMP:0]      row_q;
            logic [RES_BITS-1:0] rom_code;

            fte_row_detect #(.N_CMP(N_CMP)) u_detect (
                .therm_i (therm_i),
                .rows_o  (row_hit)
            );

            // Stage 1: capture the boundary rows of a valid sample
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (therm_vld_i) begin
                    row_q <= row_hit;
                end
            end

            fte_row_rom #(.N_CMP(N_CMP), .RES_BITS(RES_BITS)) u_rom (
                .rows_i (row_q),
                .code_o (rom_code)
            );

            assign s1_code = rom_code;
        end else begin : g_gray
            logic [RES_BITS-1:0] gray_d;
            logic [RES_BITS-1:0] gray_q;
            logic [RES_BITS-1:0] bin_d;

            fte_gray_map #(.RES_BITS(RES_BITS), .N_CMP(N_CMP)) u_map (
                .therm_i (therm_i),
                .gray_o  (gray_d)
            );

            // Stage 1: capture the Gray word of a valid sample
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    gray_q <= '0;
                end else if (therm_vld_i) begin
                    gray_q <= gray_d;
                end
            end

            fte_gray_decode #(.RES_BITS(RES_BITS)) u_dec (
                .gray_i (gray_q),
                .bin_o  (bin_d)
            );

            assign s1_code = bin_d;
        end
    endgenerate

    // Stage 1 valid tracks the sampled strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= therm_vld_i;
        end
    end

    // Stage 2: register the binary result; hold it through idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o     <= '0;
            code_vld_o <= 1'b0;
        end else begin
            code_vld_o <= s1_vld;
            if (s1_vld) begin
                code_o <= s1_code;
            end
        end
    end

endmodule

// File: rtl/flash_therm_enc_chk.sv
// Port-level checker for flash_therm_enc, attached by bind.
// Assumes: same RES_BITS as the bound instance.
module flash_therm_enc_chk #(
    parameter int RES_BITS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [(2**RES_BITS)-2:0] therm_i,
    input logic                     therm_vld_i,
    input logic [RES_BITS-1:0]      code_o,
    input logic                     code_vld_o
);

    localparam int N_CMP = (1 << RES_BITS) - 1;

    logic [1:0]       age;
    logic             was_rst;
    logic             in_clean;
    logic [N_CMP-1:0] therm_inc;

    // Count edges since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // Remember that the previous edge saw reset asserted
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // A clean word is a run of ones from bit 0 (x & (x+1) == 0)
    assign therm_inc = therm_i + 1'b1;
    assign in_clean  = ((therm_i & therm_inc) == '0);

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (code_vld_o == $past(therm_vld_i, 2)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && !$past(therm_vld_i, 2)) |-> $stable(code_o));

    // R1
    clean_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && $past(therm_vld_i, 2) && $past(in_clean, 2))
        |-> (int'(code_o) == $past($countones(therm_i), 2)));

    // R2
    full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && $past(therm_vld_i, 2) && $past(&therm_i, 2))
        |-> (&code_o));

    // R5
    always @(posedge clk) begin
        if (was_rst == 1'b1) begin
            reset_state_chk: assert (code_o == '0 && code_vld_o == 1'b0);
        end
    end

endmodule

bind flash_therm_enc flash_therm_enc_chk #(.RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/flash_therm_enc_tb_top.sv
`timescale 1ns/1ps
module flash_therm_enc_tb_top;
    import fte_pkg::*;

    localparam int B = 4;
    localparam int N = (1 << B) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] therm = '0;
    logic         tvld = 1'b0;
    logic [B-1:0] code_r, code_g;
    logic         vld_r, vld_g;

    always #4 clk = ~clk;   // 125 MHz

    flash_therm_enc #(.RES_BITS(B), .ENC_STYLE(ENC_ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .therm_i(therm), .therm_vld_i(tvld),
        .code_o(code_r), .code_vld_o(vld_r));

    flash_therm_enc #(.RES_BITS(B), .ENC_STYLE(ENC_GRAY)) dut_g_i (
        .clk(clk), .rst_n(rst_n), .therm_i(therm), .therm_vld_i(tvld),
        .code_o(code_g), .code_vld_o(vld_g));

    typedef struct {
        int    due;
        int    exp_r;
        int    exp_g;
        string tag;
    } item_t;

    item_t sbq[$];
    item_t it;
    int    cyc = 0, n_chk = 0, n_fail = 0;
    int    last_r = 0, last_g = 0;
    bit    mon_on = 1'b0, done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Threshold T_k with out-of-range levels reading 0
    function automatic bit tb_t(input logic [N-1:0] t, input int k);
        return (k >= 1 && k <= N) ? t[k-1] : 1'b0;
    endfunction

    // Row encoder model from R6/R7
    function automatic int row_model(input logic [N-1:0] t);
        int best = 0;
        for (int i = 0; i <= N; i++) begin
            bit lo = (i - 1 <= 0) ? 1'b1 : tb_t(t, i - 1);
            bit at = (i <= 0) ? 1'b1 : tb_t(t, i);
            if (lo && at && !tb_t(t, i + 1)) best = i;
        end
        return best;
    endfunction

    // Gray encoder model from R8
    function automatic int gray_model(input logic [N-1:0] t);
        int g = 0, res = 0, par = 0;
        for (int j = 0; j < B; j++)
            for (int m = (1 << j); m <= N; m += (1 << (j + 2)))
                if (tb_t(t, m) && !tb_t(t, m + (1 << (j + 1)))) g |= (1 << j);
        for (int k = B - 1; k >= 0; k--) begin
            par ^= (g >> k) & 1;
            res |= par << k;
        end
        return res;
    endfunction

    // Driver: apply one sample and queue its expectation
    task automatic drive(input logic [N-1:0] t, input bit v,
                         input int er, input int eg, input string tag);
        item_t x;
        @(negedge clk);
        therm = t;
        tvld  = v;
        if (v) begin
            x.due = cyc + 2; x.exp_r = er; x.exp_g = eg; x.tag = tag;
            sbq.push_back(x);
        end
    endtask

    task automatic drive_model(input logic [N-1:0] t, input string tag);
        drive(t, 1'b1, row_model(t), gray_model(t), tag);
    endtask

    // Monitor: pop and compare on each result, check hold on idle
    always @(negedge clk) begin
        if (mon_on) begin
            if (vld_r !== vld_g) check(1'b0, "R3", "valid agreement", vld_r, vld_g);
            if (vld_r) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R3", "unexpected valid", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    check(cyc == it.due, "R3", "valid cycle", cyc, it.due);
                    check(int'(code_r) == it.exp_r, it.tag, "row code", code_r, it.exp_r);
                    check(int'(code_g) == it.exp_g, it.tag, "gray code", code_g, it.exp_g);
                    last_r = code_r;
                    last_g = code_g;
                end
            end else begin
                check(int'(code_r) == last_r, "R4", "row hold", code_r, last_r);
                check(int'(code_g) == last_g, "R4", "gray hold", code_g, last_g);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R5: reset with active-looking inputs
        therm = '1;
        tvld  = 1'b1;
        repeat (4) @(negedge clk);
        check(code_r == '0 && code_g == '0, "R5", "reset code", code_r, 0);
        check(!vld_r && !vld_g, "R5", "reset valid", vld_r, 0);
        rst_n  = 1'b1;
        tvld   = 1'b0;
        mon_on = 1'b1;

        // R1/R2: every clean level, with idle gaps (R4) carrying garbage
        for (int k = 0; k <= N; k++) begin
            drive(N'((1 << k) - 1), 1'b1, k, k, (k == 0 || k == N) ? "R2" : "R1");
            if (k % 3 == 1) drive(N'(16'h5A5A), 1'b0, 0, 0, "R4");
        end

        // R6: lone 1 above a clean run is ignored by the row encoder
        drive(N'(16'h011F), 1'b1, 5, gray_model(N'(16'h011F)), "R6");
        drive(N'(16'h4007), 1'b1, 3, gray_model(N'(16'h4007)), "R6");

        // R7: two lit rows select the higher one; R8 example on the same word
        drive(N'(16'h00F7), 1'b1, 8, 15, "R7");
        drive(N'(16'h3EFF), 1'b1, 14, gray_model(N'(16'h3EFF)), "R7");
        drive(N'(16'h00F7), 1'b1, row_model(N'(16'h00F7)), 15, "R8");

        // R8: pseudo-random words, with occasional idle cycles
        lfsr = 16'hACE1;
        for (int n = 0; n < 48; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[5]) drive(lfsr[N-1:0], 1'b0, 0, 0, "R4");
            else                    drive_model(lfsr[N-1:0], "R8");
        end

        // Drain and confirm every sample produced a result
        repeat (4) drive('0, 1'b0, 0, 0, "R4");
        check(sbq.size() == 0, "R3", "results outstanding", sbq.size(), 0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule